// File: doc/BRIEF.md
# USB Receive Endpoint Control and Status

This block holds the control state of one receive endpoint in a USB device controller. Software programs it through a byte-wide register. That register selects the transfer type, automatic release of the packet-ready flag, DMA request gating, DMA interrupt pacing and NYET suppression. In isochronous mode the same bit that suppresses NYET becomes a PID-error status flag.

The block raises packet-ready when a packet lands in the endpoint FIFO. It counts the bytes that the CPU or the DMA engine reads out of the FIFO. From that count it can drop packet-ready by itself. It drives the DMA request and the DMA interrupt. For every bulk or interrupt packet received, it picks the handshake (ACK or NYET) from the free room left in the FIFO.

All event inputs are single-cycle strobes and are always accepted. There is no back-pressure on any pin: the FIFO, the DMA engine and the line logic must present each event once, in the cycle it happens.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00, and `rx_rdy`, `dma_req`, `dma_irq`, `hs_vld` and `hs_nyet` are all 0.
- R2: Register layout: bit 7 = auto-release, bit 6 = isochronous, bit 5 = DMA enable, bit 4 = NYET-off / PID-error, bit 3 = DMA interrupt mode. Bits 2:0 always read 0, whatever is written to them.
- R3: `rx_rdy` reads 1 in the cycle after a `pkt_rcv` strobe. It reads 0 in the cycle after a `rdy_clr` strobe. With auto-release off, unloads never clear it.
- R4: With auto-release on, `rx_rdy` clears after the unload that makes the unloaded byte count exactly equal `max_pkt`. A CPU unload adds 1 byte and a DMA beat adds 4 bytes. A count that stays below `max_pkt`, or that steps past it without landing on it, leaves `rx_rdy` set.
- R5: A `pkt_rcv` strobe restarts the unloaded byte count at zero.
- R6: In bulk/interrupt mode, each `pkt_rcv` gives a one-cycle `hs_vld` in the next cycle. `hs_nyet` is 1 (NYET) when bit 4 is 0 and the free room left after the packet, `fifo_room - pkt_len` (floored at 0), is less than `max_pkt`. Otherwise `hs_nyet` is 0 (ACK). In isochronous mode no handshake is given.
- R7: In bulk/interrupt mode with bit 4 set, every received packet is ACKed, even one that leaves no room.
- R8: In isochronous mode a `pid_err` strobe sets bit 4. In bulk/interrupt mode `pid_err` has no effect on the register.
- R9: `dma_req` is 1 exactly while DMA enable and `rx_rdy` are both 1.
- R10: With DMA enable set, mode 0 gives a one-cycle `dma_irq` in the cycle that `rx_rdy` first reads 0 after a packet. Mode 1 gives `dma_irq` only in the cycle after `dma_done`. With DMA enable clear there is no `dma_irq`.
- R11: A write that clears the DMA mode bit while DMA enable is currently set keeps the old mode. This includes a write that clears both bits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| max_pkt | input | MAXP_W | Programmed maximum packet size in bytes |
| fifo_room | input | ROOM_W | Free bytes in the receive FIFO before the incoming packet |
| pkt_rcv | input | 1 | A good packet was received |
| pkt_len | input | MAXP_W | Byte count of the received packet |
| pid_err | input | 1 | The received packet had a PID error |
| rdy_clr | input | 1 | Software clear of packet-ready |
| unload_cpu | input | 1 | One byte read from the FIFO by the CPU |
| unload_dma | input | 1 | One 4-byte DMA read from the FIFO |
| dma_done | input | 1 | Whole DMA transfer finished |
| rx_rdy | output | 1 | Packet-ready flag |
| dma_req | output | 1 | DMA request |
| dma_irq | output | 1 | DMA interrupt pulse |
| hs_vld | output | 1 | A handshake is due |
| hs_nyet | output | 1 | Handshake is NYET (1) or ACK (0) |

## Verification
A wrong unload count shows up on `rx_rdy` and `dma_req`. They either fall early on a short packet or never fall on a full one, and this is visible on the cycle after the deciding unload. A stale DMA mode bit shows up as a `dma_irq` pulse that is missing or extra, one cycle after the freeing unload or after `dma_done`. A wrong mode bit or wrong room arithmetic shows up on `hs_vld`/`hs_nyet` one cycle after the packet strobe. Register corruption, such as a lost PID-error flag or a mode cleared too early, is visible on `csr_rdata` in the cycle after the write or strobe.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;
  typedef struct packed {
    logic auto_rel;
    logic iso;
    logic dma_en;
    logic nyet_pid;
    logic dma_mode;
  } ep_cfg_t;

  localparam int BIT_AUTO = 7;
  localparam int BIT_ISO  = 6;
  localparam int BIT_DEN  = 5;
  localparam int BIT_NP   = 4;
  localparam int BIT_DMOD = 3;
  localparam int DMA_BEAT_BYTES = 4;
endpackage

// File: rtl/rx_ep_csr.sv
module rx_ep_csr
  import usb_rx_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       pid_err,
  output ep_cfg_t    cfg,
  output logic [7:0] rdata
);
  logic keep_mode;

  // clearing the mode bit is refused while DMA is currently enabled
  assign keep_mode = cfg.dma_en && !wdata[BIT_DMOD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (we) begin
        cfg.auto_rel <= wdata[BIT_AUTO];
        cfg.iso      <= wdata[BIT_ISO];
        cfg.dma_en   <= wdata[BIT_DEN];
        cfg.nyet_pid <= wdata[BIT_NP];
        cfg.dma_mode <= keep_mode ? cfg.dma_mode : wdata[BIT_DMOD];
      end
      if (cfg.iso && pid_err) cfg.nyet_pid <= 1'b1;
    end
  end

  assign rdata = {cfg.auto_rel, cfg.iso, cfg.dma_en, cfg.nyet_pid, cfg.dma_mode, 3'b000};

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && cfg.dma_en && !wdata[BIT_DMOD]) |=> (cfg.dma_mode == $past(cfg.dma_mode))); // R11
  AST_PIDERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.iso && pid_err) |=> cfg.nyet_pid); // R8
endmodule

// File: rtl/rx_ep_unload.sv
module rx_ep_unload #(
  parameter int MAXP_W = 11,
  parameter int BEAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_rel,
  input  logic [MAXP_W-1:0] max_pkt,
  input  logic              pkt_rcv,
  input  logic              rdy_clr,
  input  logic              unload_cpu,
  input  logic              unload_dma,
  output logic              rx_rdy,
  output logic              rdy_fall
);
  localparam int CNT_W = MAXP_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt, cnt_nxt, inc, sum;
  logic             hit, rdy_nxt;

  always_comb begin
    inc = (unload_cpu ? CNT_W'(1) : '0) + (unload_dma ? CNT_W'(BEAT) : '0);
    sum = (cnt > CNT_MAX - inc) ? CNT_MAX : cnt + inc;
    hit = rx_rdy && auto_rel && (inc != '0) && (sum == CNT_W'(max_pkt));
    if (pkt_rcv)              rdy_nxt = 1'b1;
    else if (rdy_clr || hit)  rdy_nxt = 1'b0;
    else                      rdy_nxt = rx_rdy;
    if (pkt_rcv || !rdy_nxt)  cnt_nxt = '0;
    else if (rx_rdy)          cnt_nxt = sum;
    else                      cnt_nxt = cnt;
    rdy_fall = rx_rdy && !rdy_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rx_rdy <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      rx_rdy <= rdy_nxt;
    end
  end

  AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rcv |=> rx_rdy); // R3
  AST_HOLD_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && !auto_rel && !rdy_clr) |=> rx_rdy); // R3
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rcv |=> (cnt == '0)); // R5
endmodule

// File: rtl/rx_ep_resp.sv
module rx_ep_resp
  import usb_rx_ep_pkg::*;
#(
  parameter int MAXP_W = 11,
  parameter int ROOM_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ep_cfg_t           cfg,
  input  logic              rx_rdy,
  input  logic              rdy_fall,
  input  logic              dma_done,
  input  logic              pkt_rcv,
  input  logic [MAXP_W-1:0] pkt_len,
  input  logic [ROOM_W-1:0] fifo_room,
  input  logic [MAXP_W-1:0] max_pkt,
  output logic              dma_req,
  output logic              dma_irq,
  output logic              hs_vld,
  output logic              hs_nyet
);
  localparam int AW = ((ROOM_W > MAXP_W) ? ROOM_W : MAXP_W) + 1;

  logic [AW-1:0] room_x, len_x, mp_x, left;
  logic          tight, irq_evt;

  always_comb begin
    room_x  = AW'(fifo_room);
    len_x   = AW'(pkt_len);
    mp_x    = AW'(max_pkt);
    left    = (room_x >= len_x) ? room_x - len_x : '0;
    tight   = left < mp_x;
    irq_evt = cfg.dma_en && (cfg.dma_mode ? dma_done : rdy_fall);
  end

  assign dma_req = cfg.dma_en && rx_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_vld  <= 1'b0;
      hs_nyet <= 1'b0;
      dma_irq <= 1'b0;
    end else begin
      hs_vld  <= pkt_rcv && !cfg.iso;
      hs_nyet <= pkt_rcv && !cfg.iso && !cfg.nyet_pid && tight;
      dma_irq <= irq_evt;
    end
  end

  AST_ISO_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_vld |-> !$past(cfg.iso)); // R6
  AST_NYET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_rcv && !cfg.iso && cfg.nyet_pid) |=> !hs_nyet); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> $past(cfg.dma_en)); // R10
  AST_NYET_IMPLIES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nyet |-> hs_vld); // R6
endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rx_ep_pkg::*;
#(
  parameter int MAXP_W = 11,
  parameter int ROOM_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic [MAXP_W-1:0] max_pkt,
  input  logic [ROOM_W-1:0] fifo_room,
  input  logic              pkt_rcv,
  input  logic [MAXP_W-1:0] pkt_len,
  input  logic              pid_err,
  input  logic              rdy_clr,
  input  logic              unload_cpu,
  input  logic              unload_dma,
  input  logic              dma_done,
  output logic              rx_rdy,
  output logic              dma_req,
  output logic              dma_irq,
  output logic              hs_vld,
  output logic              hs_nyet
);
  ep_cfg_t cfg;
  logic    rdy_fall;

  rx_ep_csr u_csr (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
    .pid_err(pid_err), .cfg(cfg), .rdata(csr_rdata)
  );

  rx_ep_unload #(.MAXP_W(MAXP_W), .BEAT(DMA_BEAT_BYTES)) u_unload (
    .clk(clk), .rst_n(rst_n), .auto_rel(cfg.auto_rel), .max_pkt(max_pkt),
    .pkt_rcv(pkt_rcv), .rdy_clr(rdy_clr), .unload_cpu(unload_cpu),
    .unload_dma(unload_dma), .rx_rdy(rx_rdy), .rdy_fall(rdy_fall)
  );

  rx_ep_resp #(.MAXP_W(MAXP_W), .ROOM_W(ROOM_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .rx_rdy(rx_rdy), .rdy_fall(rdy_fall),
    .dma_done(dma_done), .pkt_rcv(pkt_rcv), .pkt_len(pkt_len),
    .fifo_room(fifo_room), .max_pkt(max_pkt), .dma_req(dma_req),
    .dma_irq(dma_irq), .hs_vld(hs_vld), .hs_nyet(hs_nyet)
  );

  AST_REQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rx_rdy); // R9
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (csr_rdata[2:0] == 3'b000)); // R2
endmodule

// File: tb/tb_usb_rx_ep_ctrl.sv
module tb_usb_rx_ep_ctrl;
  localparam int MAXP_W = 11;
  localparam int ROOM_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic [MAXP_W-1:0] max_pkt = '0;
  logic [ROOM_W-1:0] fifo_room = '0;
  logic pkt_rcv = 1'b0;
  logic [MAXP_W-1:0] pkt_len = '0;
  logic pid_err = 1'b0, rdy_clr = 1'b0, unload_cpu = 1'b0, unload_dma = 1'b0, dma_done = 1'b0;
  logic rx_rdy, dma_req, dma_irq, hs_vld, hs_nyet;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  usb_rx_ep_ctrl #(.MAXP_W(MAXP_W), .ROOM_W(ROOM_W)) dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .max_pkt(max_pkt), .fifo_room(fifo_room),
    .pkt_rcv(pkt_rcv), .pkt_len(pkt_len), .pid_err(pid_err), .rdy_clr(rdy_clr),
    .unload_cpu(unload_cpu), .unload_dma(unload_dma), .dma_done(dma_done),
    .rx_rdy(rx_rdy), .dma_req(dma_req), .dma_irq(dma_irq),
    .hs_vld(hs_vld), .hs_nyet(hs_nyet)
  );

  typedef struct packed {
    logic [12:0] room;
    logic [10:0] len;
    logic        iso;
    logic        noff;
    logic        e_vld;
    logic        e_nyet;
  } hs_vec_t;

  localparam hs_vec_t VEC [0:8] = '{
    '{13'd512, 11'd64, 1'b0, 1'b0, 1'b1, 1'b0},
    '{13'd100, 11'd64, 1'b0, 1'b0, 1'b1, 1'b1},
    '{13'd128, 11'd64, 1'b0, 1'b0, 1'b1, 1'b0},
    '{13'd127, 11'd64, 1'b0, 1'b0, 1'b1, 1'b1},
    '{13'd64,  11'd64, 1'b0, 1'b0, 1'b1, 1'b1},
    '{13'd64,  11'd64, 1'b0, 1'b1, 1'b1, 1'b0},
    '{13'd30,  11'd64, 1'b0, 1'b0, 1'b1, 1'b1},
    '{13'd30,  11'd64, 1'b0, 1'b1, 1'b1, 1'b0},
    '{13'd0,   11'd64, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); csr_we = 1'b1; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic pkt(input logic [MAXP_W-1:0] len);
    @(negedge clk); pkt_rcv = 1'b1; pkt_len = len;
    @(negedge clk); pkt_rcv = 1'b0;
  endtask

  task automatic ucpu();
    @(negedge clk); unload_cpu = 1'b1;
    @(negedge clk); unload_cpu = 1'b0;
  endtask

  task automatic udma();
    @(negedge clk); unload_dma = 1'b1;
    @(negedge clk); unload_dma = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); rdy_clr = 1'b1;
    @(negedge clk); rdy_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata", csr_rdata, 8'h00);
    check("R1 outs", {rx_rdy, dma_req, dma_irq, hs_vld, hs_nyet}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {csr_rdata, rx_rdy, dma_req, dma_irq, hs_vld, hs_nyet}, 13'h0);

    // handshake table: R6 R7
    max_pkt = 11'd64;
    for (int i = 0; i < 9; i++) begin
      wr({1'b0, VEC[i].iso, 1'b0, VEC[i].noff, 4'b0});
      fifo_room = VEC[i].room;
      pkt(VEC[i].len);
      check(VEC[i].noff ? "R7 hs" : "R6 hs", {hs_vld, hs_nyet}, {VEC[i].e_vld, VEC[i].e_nyet});
      @(negedge clk);
      check("R6 hs pulse", hs_vld, 1'b0);
      clr();
    end

    // R2 reserved bits, then R11 mode protect
    wr(8'hFF);
    check("R2 rsvd", csr_rdata, 8'hF8);
    wr(8'h00);
    check("R11 mode kept", csr_rdata, 8'h08);
    wr(8'h00);
    check("R11 mode cleared later", csr_rdata, 8'h00);

    // R3 R4 cpu unload with auto-release
    max_pkt = 11'd4;
    wr(8'h80);
    pkt(11'd4);
    check("R3 set", rx_rdy, 1'b1);
    ucpu(); ucpu(); ucpu();
    check("R4 short stays", rx_rdy, 1'b1);
    ucpu();
    check("R4 exact clears", rx_rdy, 1'b0);

    // R3 no auto-release
    wr(8'h00);
    pkt(11'd4);
    ucpu(); ucpu(); ucpu(); ucpu(); ucpu();
    check("R3 held", rx_rdy, 1'b1);
    clr();
    check("R3 sw clear", rx_rdy, 1'b0);

    // R5 restart
    wr(8'h80);
    pkt(11'd4);
    ucpu(); ucpu();
    pkt(11'd4);
    ucpu(); ucpu();
    check("R5 restart", rx_rdy, 1'b1);
    ucpu(); ucpu();
    check("R5 clears at max", rx_rdy, 1'b0);

    // R9 R10 dma mode 0
    max_pkt = 11'd8;
    wr(8'hA0);
    pkt(11'd8);
    check("R9 req on", dma_req, 1'b1);
    udma();
    check("R9 req mid", {rx_rdy, dma_req, dma_irq}, 3'b110);
    udma();
    check("R10 mode0 irq", {rx_rdy, dma_req, dma_irq}, 3'b001);
    @(negedge clk);
    check("R10 irq pulse", dma_irq, 1'b0);

    // R4 overshoot with dma beats
    max_pkt = 11'd10;
    pkt(11'd10);
    udma(); udma(); udma();
    check("R4 overshoot", rx_rdy, 1'b1);
    clr();
    check("R10 mode0 on sw clear", {rx_rdy, dma_irq}, 2'b01);

    // R10 mode 1
    max_pkt = 11'd4;
    wr(8'hA8);
    pkt(11'd4);
    udma();
    check("R10 mode1 no irq on unload", {rx_rdy, dma_irq}, 2'b00);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    check("R10 mode1 irq on done", dma_irq, 1'b1);

    // DMA disabled: R9 R10
    wr(8'h80);
    check("R11 mode kept on disable", csr_rdata, 8'h88);
    pkt(11'd4);
    check("R9 no req", dma_req, 1'b0);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    check("R10 no irq when off", dma_irq, 1'b0);
    clr();

    // R8 pid error
    wr(8'h40);
    check("R8 iso set", csr_rdata, 8'h40);
    @(negedge clk); pid_err = 1'b1;
    @(negedge clk); pid_err = 1'b0;
    check("R8 pid flag", csr_rdata, 8'h50);
    wr(8'h00);
    @(negedge clk); pid_err = 1'b1;
    @(negedge clk); pid_err = 1'b0;
    check("R8 bulk ignore", csr_rdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule